// File: doc/BRIEF.md
# Multi-Link Top-Two Candidate Selector

Every clock, this block receives one trigger byte from each of up to eight tower links. It picks the two muon candidates with the highest transverse-momentum threshold code. It then packs those two candidates into a single 32-bit word, together with the bunch-crossing number that belongs to that input cycle.

The block is a fixed three-stage pipeline and accepts new input on every cycle:

1. Each link byte is decoded, and the result is registered.
2. A tree of top-two merge units reduces all links to a best pair, and the pair is registered.
3. The pair and its delayed bunch-crossing tag are packed into the output register.

A per-link enable mask lets a sector that populates only six or seven links exclude the links that are not fitted.

Top module: `muon_top2_select`

## Requirements
- R1: A link byte is a candidate only if bit 7 (valid) is 1 and its threshold code in bits 6:4 is non-zero. Bits 3:0 carry the region code. Any other byte contributes nothing.
- R2: A link whose bit in `link_en_i` is 0 is never reported, whatever its byte holds.
- R3: Candidate 1 is the best candidate and candidate 2 is the second best. "Best" means the higher threshold code.
- R4: Between equal threshold codes, the lower link index ranks higher.
- R5: The two reported candidates always come from different links.
- R6: If only one candidate exists, the candidate-2 field is all zero. If no candidate exists, both candidate fields are all zero.
- R7: Word layout:
  - bits 9:0 hold candidate 1 and bits 19:10 hold candidate 2.
  - Each candidate field is {link index[2:0], threshold[2:0], region[3:0]}, with the link index in the top bits.
  - bits 31:20 hold the bunch-crossing number.
- R8: Link inputs sampled on one rising edge appear on `word_o` right after the third rising edge counted from that edge. A new input set is accepted on every edge.
- R9: The bunch-crossing counter advances by one each cycle and returns from 3563 to 0.
- R10: When `bcr_i` is high at a rising edge, the counter becomes 0 at that edge. Counting then resumes from 0.
- R11: The bunch-crossing field of an output word equals the counter value during the cycle in which its link inputs were sampled.
- R12: While `rst_ni` is low, `word_o` is zero and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_word_i | input | 64 | Eight link bytes; link k occupies bits 8k+7:8k |
| link_en_i | input | 8 | Per-link enable mask |
| bcr_i | input | 1 | Synchronous bunch-counter reset |
| word_o | output | 32 | Packed top-two candidates with bunch-crossing tag |

## Verification
A wrong internal state shows up on `word_o` exactly three edges after the input that exposes it. The block has no state that persists beyond the pipeline, except the bunch-crossing counter.

- A faulty comparison or tie rule gives a wrong link index in one of the two fields.
- A lost mask or valid check lets a disabled or empty link appear in a field.
- A counter fault is different: it puts a wrong tag on every later word until the next bunch-counter reset. The stream check therefore compares the tag of each word with an independent count.

// File: rtl/muon_sel_pkg.sv
package muon_sel_pkg;
  localparam int LINK_W = 8;
  localparam int PT_W   = 3;
  localparam int ROI_W  = 4;
  localparam int IDX_W  = 3;
  localparam int CAND_W = IDX_W + PT_W + ROI_W;

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
    logic [PT_W-1:0]  pt;
    logic [ROI_W-1:0] roi;
  } cand_t;

  // a outranks b: higher threshold, then lower link index
  function automatic logic outranks(cand_t a, cand_t b);
    return a.vld && (!b.vld || (a.pt > b.pt) || ((a.pt == b.pt) && (a.idx < b.idx)));
  endfunction

  function automatic logic [CAND_W-1:0] pack_cand(cand_t c);
    return c.vld ? {c.idx, c.pt, c.roi} : '0;
  endfunction
endpackage

// File: rtl/link_decode.sv
module link_decode
  import muon_sel_pkg::*;
#(
  parameter int unsigned LINK_IDX = 0
) (
  input  logic [LINK_W-1:0] word_i,
  input  logic              en_i,
  output cand_t             cand_o
);
  logic [PT_W-1:0]  pt;
  logic [ROI_W-1:0] roi;
  logic             flag;
  logic             vld;

  assign flag = word_i[LINK_W-1];
  assign pt   = word_i[LINK_W-2 -: PT_W];
  assign roi  = word_i[ROI_W-1:0];
  assign vld  = en_i && flag && (pt != '0);

  always_comb begin
    cand_o = '0;
    if (vld) begin
      cand_o.vld = 1'b1;
      cand_o.idx = IDX_W'(LINK_IDX);
      cand_o.pt  = pt;
      cand_o.roi = roi;
    end
  end
endmodule

// File: rtl/top2_merge.sv
module top2_merge
  import muon_sel_pkg::*;
(
  input  cand_t a_hi_i,
  input  cand_t a_lo_i,
  input  cand_t b_hi_i,
  input  cand_t b_lo_i,
  output cand_t hi_o,
  output cand_t lo_o
);
  // inputs come from disjoint link sets, each pair already ranked
  always_comb begin
    if (outranks(a_hi_i, b_hi_i)) begin
      hi_o = a_hi_i;
      lo_o = outranks(a_lo_i, b_hi_i) ? a_lo_i : b_hi_i;
    end else begin
      hi_o = b_hi_i;
      lo_o = outranks(a_hi_i, b_lo_i) ? a_hi_i : b_lo_i;
    end
  end
endmodule

// File: rtl/top2_tree.sv
module top2_tree
  import muon_sel_pkg::*;
#(
  parameter int unsigned N_LINKS = 8
) (
  input  cand_t leaf_i [N_LINKS],
  output cand_t hi_o,
  output cand_t lo_o
);
  localparam int unsigned LVL   = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
  localparam int unsigned NP    = 1 << LVL;
  localparam int unsigned NODES = 2 * NP - 1;

  cand_t node_hi [NODES];
  cand_t node_lo [NODES];

  for (genvar k = 0; k < NP; k++) begin : g_leaf
    if (k < N_LINKS) begin : g_used
      assign node_hi[NP-1+k] = leaf_i[k];
    end else begin : g_pad
      assign node_hi[NP-1+k] = '0;
    end
    assign node_lo[NP-1+k] = '0;
  end

  for (genvar i = 0; i < NP - 1; i++) begin : g_node
    top2_merge u_merge (
      .a_hi_i (node_hi[2*i+1]),
      .a_lo_i (node_lo[2*i+1]),
      .b_hi_i (node_hi[2*i+2]),
      .b_lo_i (node_lo[2*i+2]),
      .hi_o   (node_hi[i]),
      .lo_o   (node_lo[i])
    );
  end

  assign hi_o = node_hi[0];
  assign lo_o = node_lo[0];
endmodule

// File: rtl/bc_counter.sv
module bc_counter #(
  parameter int unsigned BC_W   = 12,
  parameter int unsigned BC_MAX = 3564
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bcr_i,
  output logic [BC_W-1:0] bc_o
);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BC_MAX - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               bc_o <= '0;
    else if (bcr_i)            bc_o <= '0;
    else if (bc_o == BC_LAST)  bc_o <= '0;
    else                       bc_o <= bc_o + BC_W'(1);
  end

  AST_BC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcr_i |=> (bc_o == '0)); // R10
  AST_BC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bcr_i && bc_o != BC_LAST) |=> (bc_o == $past(bc_o) + BC_W'(1))); // R9
  AST_BC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bcr_i && bc_o == BC_LAST) |=> (bc_o == '0)); // R9
endmodule

// File: rtl/muon_top2_select.sv
module muon_top2_select
  import muon_sel_pkg::*;
#(
  parameter int unsigned N_LINKS = 8,
  parameter int unsigned BC_W    = 12,
  parameter int unsigned BC_MAX  = 3564,
  localparam int unsigned WORD_W = BC_W + 2 * CAND_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_LINKS*LINK_W-1:0] link_word_i,
  input  logic [N_LINKS-1:0]        link_en_i,
  input  logic                      bcr_i,
  output logic [WORD_W-1:0]         word_o
);
  logic [BC_W-1:0] bc_q;
  cand_t           dec   [N_LINKS];
  cand_t           s1_c  [N_LINKS];
  logic [BC_W-1:0] s1_bc;
  cand_t           tree_hi, tree_lo;
  cand_t           s2_hi, s2_lo;
  logic [BC_W-1:0] s2_bc;

  bc_counter #(.BC_W(BC_W), .BC_MAX(BC_MAX)) u_bc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bcr_i  (bcr_i),
    .bc_o   (bc_q)
  );

  for (genvar k = 0; k < N_LINKS; k++) begin : g_dec
    link_decode #(.LINK_IDX(k)) u_dec (
      .word_i (link_word_i[k*LINK_W +: LINK_W]),
      .en_i   (link_en_i[k]),
      .cand_o (dec[k])
    );
  end

  // stage 1: decoded links
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_LINKS; k++) s1_c[k] <= '0;
      s1_bc <= '0;
    end else begin
      for (int k = 0; k < N_LINKS; k++) s1_c[k] <= dec[k];
      s1_bc <= bc_q;
    end
  end

  top2_tree #(.N_LINKS(N_LINKS)) u_tree (
    .leaf_i (s1_c),
    .hi_o   (tree_hi),
    .lo_o   (tree_lo)
  );

  // stage 2: ranked pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_hi <= '0;
      s2_lo <= '0;
      s2_bc <= '0;
    end else begin
      s2_hi <= tree_hi;
      s2_lo <= tree_lo;
      s2_bc <= s1_bc;
    end
  end

  // stage 3: packed word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= {s2_bc, pack_cand(s2_lo), pack_cand(s2_hi)};
  end

  // output field views for checking
  logic [CAND_W-1:0] o1_f, o2_f;
  logic [IDX_W-1:0]  o1_idx, o2_idx;
  logic [PT_W-1:0]   o1_pt, o2_pt;
  assign o1_f   = word_o[CAND_W-1:0];
  assign o2_f   = word_o[2*CAND_W-1:CAND_W];
  assign o1_idx = o1_f[CAND_W-1 -: IDX_W];
  assign o2_idx = o2_f[CAND_W-1 -: IDX_W];
  assign o1_pt  = o1_f[ROI_W +: PT_W];
  assign o2_pt  = o2_f[ROI_W +: PT_W];

  AST_CAND_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (o2_f != '0) |-> (o1_idx != o2_idx)); // R5
  AST_RANK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (o2_f != '0) |-> ((o1_pt > o2_pt) || (o1_pt == o2_pt && o1_idx < o2_idx))); // R3
  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (o1_f == '0) |-> (o2_f == '0)); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (o1_pt == '0) |-> (o1_f == '0)); // R6
  AST_MASKED_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (o1_pt != '0) |-> (|($past(link_en_i, 3) & (N_LINKS'(1) << o1_idx)))); // R2
endmodule

// File: tb/muon_top2_select_bench.sv
`timescale 1ns/1ps
module muon_top2_select_bench;
  localparam int NV = 10;
  localparam int LAST_BC = 3563;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [63:0] link_word_i;
  logic [7:0]  link_en_i;
  logic        bcr_i;
  logic [31:0] word_o;

  int checks = 0;
  int errors = 0;
  int model_bc;
  int exp_bc [NV];

  always #10 clk_i = ~clk_i;

  muon_top2_select u_muon_top2_select (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_word_i (link_word_i),
    .link_en_i   (link_en_i),
    .bcr_i       (bcr_i),
    .word_o      (word_o)
  );

  // independent bunch-crossing model (R9, R10, R12)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 model_bc <= 0;
    else if (bcr_i)              model_bc <= 0;
    else if (model_bc == LAST_BC) model_bc <= 0;
    else                         model_bc <= model_bc + 1;
  end

  // stimulus: links 7..0 as bytes, enable mask, expected {v,idx,pt,roi}
  localparam logic [63:0] V_LINK [NV] = '{
    64'h0000_0000_0000_0000,
    64'h0000_0000_00D3_0000,
    64'hC200_E900_0000_00B1,
    64'h00F5_0000_F600_F400,
    64'h0000_0071_0000_0090,
    64'h00AA_0000_8F00_0000,
    64'hF7F6_F5F4_F3F2_F1F0,
    64'hFFFE_9090_9090_9090,
    64'h0000_B3F1_00B2_0000,
    64'hF7F6_F5F4_F3F2_F1F0
  };
  localparam logic [7:0] V_EN [NV] = '{
    8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'b1110_1100, 8'hFF, 8'hFF, 8'h00
  };
  localparam logic [10:0] V_C1 [NV] = '{
    11'd0,
    {1'b1, 3'd2, 3'd5, 4'd3},
    {1'b1, 3'd5, 3'd6, 4'd9},
    {1'b1, 3'd1, 3'd7, 4'd4},
    {1'b1, 3'd0, 3'd1, 4'd0},
    {1'b1, 3'd6, 3'd2, 4'd10},
    {1'b1, 3'd2, 3'd7, 4'd2},
    {1'b1, 3'd6, 3'd7, 4'd14},
    {1'b1, 3'd4, 3'd7, 4'd1},
    11'd0
  };
  localparam logic [10:0] V_C2 [NV] = '{
    11'd0,
    11'd0,
    {1'b1, 3'd7, 3'd4, 4'd2},
    {1'b1, 3'd3, 3'd7, 4'd6},
    11'd0,
    11'd0,
    {1'b1, 3'd3, 3'd7, 4'd3},
    {1'b1, 3'd7, 3'd7, 4'd15},
    {1'b1, 3'd2, 3'd3, 4'd2},
    11'd0
  };
  localparam string V_REQ [NV] = '{
    "R6 empty", "R1 R6 single", "R3 R7 ranking", "R4 R5 tie",
    "R1 valid bit", "R1 zero pt", "R2 mask", "R4 tie high links",
    "R5 R3 distinct", "R2 all masked"
  };

  function automatic logic [31:0] mk_word(int bc, logic [10:0] c1, logic [10:0] c2);
    logic [9:0] f1, f2;
    f1 = c1[10] ? c1[9:0] : 10'd0;
    f2 = c2[10] ? c2[9:0] : 10'd0;
    return {12'(bc), f2, f1};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int wait_n;
    rst_ni = 1'b0;
    link_word_i = 64'hF7F6_F5F4_F3F2_F1F0;
    link_en_i = 8'hFF;
    bcr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R12 reset word", word_o, 32'd0);
    link_word_i = '0;
    rst_ni = 1'b1;

    // back-to-back stream, R8 throughput and R11 tag
    for (int n = 0; n < NV + 3; n++) begin
      @(negedge clk_i);
      if (n >= 3)
        check(V_REQ[n-3], word_o, mk_word(exp_bc[n-3], V_C1[n-3], V_C2[n-3]));
      if (n < NV) begin
        link_word_i = V_LINK[n];
        link_en_i   = V_EN[n];
        exp_bc[n]   = model_bc;
      end else begin
        link_word_i = '0;
        link_en_i   = 8'hFF;
      end
    end

    // R8 latency: single pulse on link 0
    @(negedge clk_i);
    link_word_i = 64'h90;
    @(negedge clk_i);
    link_word_i = '0;
    @(negedge clk_i);
    check("R8 not before third edge", {22'd0, word_o[9:0]}, 32'd0);
    @(negedge clk_i);
    check("R8 on third edge", {22'd0, word_o[9:0]}, {22'd0, 3'd0, 3'd1, 4'd0});

    // R10 synchronous clear
    bcr_i = 1'b1;
    @(negedge clk_i);
    bcr_i = 1'b0;
    link_word_i = 64'hD3_0000;
    repeat (3) @(negedge clk_i);
    check("R10 R11 tag after clear", word_o, mk_word(0, {1'b1, 3'd2, 3'd5, 4'd3}, 11'd0));
    link_word_i = '0;

    // R9 wrap
    wait_n = 0;
    while (model_bc != LAST_BC && wait_n < 5000) begin
      @(negedge clk_i);
      wait_n++;
    end
    repeat (3) @(negedge clk_i);
    check("R9 last value", {20'd0, word_o[31:20]}, 32'd3563);
    @(negedge clk_i);
    check("R9 wrap to zero", {20'd0, word_o[31:20]}, 32'd0);
    @(negedge clk_i);
    check("R9 step after wrap", {20'd0, word_o[31:20]}, 32'd1);

    // R12 reset mid-run clears output
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R12 reset again", word_o, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule